// File: doc/BRIEF.md
# Queue-Aware Host Control Register Block

This block is the slave-side register file of a host bus controller. It holds four 32-bit words: configuration, error capture, command/status and interrupt enable. A host writes one word per cycle through a word-indexed write port and reads any word combinationally through a separate read port. The block does not move queue entries or run DMA. It turns the status of four request queues and four response queues into a single level-sensitive interrupt.

A response queue raises the interrupt when it holds work and its enable bit is set. A request queue raises it when it has free space, which is shown by a clear status bit, and its enable bit is set. The block also captures bus-side access errors in sticky flags, keeps a sticky flag for non-queued events, and produces a one-cycle soft-reset pulse. The configuration word only stores burst, parity, bus-mode and bank-select settings and drives them out on ports.

Word index 0 selects configuration (byte offset 0x00). Index 1 selects error capture (0x04). Index 2 selects command/status (0x08). Index 3 selects interrupt enable (0x0C).

Top module: `qhost_regs`

## Requirements
- R1: After reset every stored word reads zero, `irq` is 0 and `soft_rst` is 0.
- R2: Only bits 26:24, 17:16, 10:8 and 5:0 of the configuration word are writable; all other bits read 0. The ports carry these fields: `burst_sel` = bits 2:0 (0 for 4, 4 for 16, 5 for 32, 6 for 64 words), `enh_mode` = bit 3, `par_chk` = bit 4, `par_test` = bit 5, `burst64` = bits 10:8, `eeprom_bank` = bits 17:16, `xram_bank` = bits 26:24.
- R3: The command/status word reads the live inputs: `rsp_ready[3:0]` in bits 19:16, `req_full[3:0]` in bits 11:8 and `idle` in bit 1. Unlisted bits read 0.
- R4: `irq` is the OR of (bits 19:16 of the command word AND enable bits 19:16) and (the inverse of bits 11:8 AND enable bits 11:8), together with the terms of R7 and R8.
- R5: A one-cycle pulse on `err_misalign`, `err_unsup` or `err_parity` sets error bit 2, 1 or 0 respectively, and the bit stays set.
- R6: Writing 1 to an error bit clears it, and writing 0 leaves it unchanged. A new error in the same cycle as its clear keeps the bit set.
- R7: Command bit 7 reads the OR of the three error bits. It drives `irq` when enable bit 7 is set.
- R8: A pulse on `nq_event` sets command bit 2, which stays set until a 1 is written to command bit 2. It drives `irq` when enable bit 2 is set.
- R9: Command bit 3 reads the same value as `irq`.
- R10: Writing 1 to command bit 0 raises `soft_rst` for exactly one cycle. Bit 0 reads 1 during that cycle, and the configuration and enable words are zero from that cycle on. The error bits are kept.
- R11: Only bits 19:16, 11:8, 7 and 2 of the enable word are writable; all other bits read 0.
- R12: Writing the command word changes none of its bits except through bits 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Word index of the read |
| rd_data | output | 32 | Read data (combinational) |
| rsp_ready | input | 4 | Response queue has work, one bit per queue |
| req_full | input | 4 | Request queue has no space, one bit per queue |
| err_misalign | input | 1 | Misaligned slave access seen |
| err_unsup | input | 1 | Unsupported slave access seen |
| err_parity | input | 1 | Slave parity error seen |
| nq_event | input | 1 | Non-queued event seen |
| idle | input | 1 | Controller idle status |
| irq | output | 1 | Interrupt request |
| soft_rst | output | 1 | One-cycle soft-reset pulse |
| burst_sel | output | 3 | Burst size code |
| enh_mode | output | 1 | Enhanced bus mode enable |
| par_chk | output | 1 | Parity check enable |
| par_test | output | 1 | Parity test enable |
| burst64 | output | 3 | 64-bit burst field |
| eeprom_bank | output | 2 | EEPROM bank select |
| xram_bank | output | 3 | External RAM bank select |

## Verification
The interrupt path is tried with a table of enable words and queue patterns. The patterns include every request queue full, a single request queue with space, work on a response queue that is disabled and then enabled, and enables set on one side only. Together they separate the inverted request polarity from the true response polarity, and show that each queue bit is gated only by its own enable bit. Directed cases cover sticky error capture, set winning over clear, the error and non-queued interrupt terms, the soft-reset pulse and the field masks.

// File: rtl/qhost_regs.sv
module qhost_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic [3:0]  rsp_ready,
  input  logic [3:0]  req_full,
  input  logic        err_misalign,
  input  logic        err_unsup,
  input  logic        err_parity,
  input  logic        nq_event,
  input  logic        idle,
  output logic        irq,
  output logic        soft_rst,
  output logic [2:0]  burst_sel,
  output logic        enh_mode,
  output logic        par_chk,
  output logic        par_test,
  output logic [2:0]  burst64,
  output logic [1:0]  eeprom_bank,
  output logic [2:0]  xram_bank
);

  localparam logic [1:0]  SEL_CFG   = 2'd0;
  localparam logic [1:0]  SEL_ERR   = 2'd1;
  localparam logic [1:0]  SEL_CMD   = 2'd2;
  localparam logic [1:0]  SEL_MSK   = 2'd3;
  localparam logic [31:0] CFG_WMASK = 32'h0703_073F;
  localparam logic [31:0] MSK_WMASK = 32'h000F_0F84;

  logic [31:0] cfg_q, msk_q, cmd_word, q_terms;
  logic [2:0]  err_q, err_clr;
  logic        nq_q, srst_q, pending;

  wire wr_cfg  = wr_en && (wr_sel == SEL_CFG);
  wire wr_err  = wr_en && (wr_sel == SEL_ERR);
  wire wr_cmd  = wr_en && (wr_sel == SEL_CMD);
  wire wr_msk  = wr_en && (wr_sel == SEL_MSK);
  wire do_srst = wr_cmd && wr_data[0];

  assign err_clr = wr_err ? wr_data[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cfg_q <= '0;
    else if (do_srst) cfg_q <= '0;
    else if (wr_cfg)  cfg_q <= wr_data & CFG_WMASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       msk_q <= '0;
    else if (do_srst) msk_q <= '0;
    else if (wr_msk)  msk_q <= wr_data & MSK_WMASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_q  <= '0;
      nq_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      err_q  <= (err_q & ~err_clr) | {err_misalign, err_unsup, err_parity};
      nq_q   <= (nq_q & ~(wr_cmd && wr_data[2])) | nq_event;
      srst_q <= do_srst;
    end

  assign q_terms = ({12'b0, rsp_ready, 16'b0} | {20'b0, ~req_full, 8'b0}) & msk_q;
  assign pending = (|q_terms) | ((|err_q) & msk_q[7]) | (nq_q & msk_q[2]);

  assign cmd_word = {12'b0, rsp_ready, 4'b0, req_full, |err_q, 3'b0,
                     pending, nq_q, idle, srst_q};

  always_comb
    case (rd_sel)
      SEL_CFG: rd_data = cfg_q;
      SEL_ERR: rd_data = {29'b0, err_q};
      SEL_CMD: rd_data = cmd_word;
      default: rd_data = msk_q;
    endcase

  assign irq         = pending;
  assign soft_rst    = srst_q;
  assign burst_sel   = cfg_q[2:0];
  assign enh_mode    = cfg_q[3];
  assign par_chk     = cfg_q[4];
  assign par_test    = cfg_q[5];
  assign burst64     = cfg_q[10:8];
  assign eeprom_bank = cfg_q[17:16];
  assign xram_bank   = cfg_q[26:24];

  // R10
  srst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R10
  srst_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (burst_sel == 3'd0 && !enh_mode && !par_chk && !par_test &&
                  burst64 == 3'd0 && eeprom_bank == 2'd0 && xram_bank == 3'd0));

  // R5
  err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_misalign || err_unsup || err_parity) |=> (|err_q));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_q) && !wr_err) |=> (|err_q));

  // R4
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == 32'd0) |-> !irq);

  // R8
  nq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nq_q && !wr_cmd) |=> nq_q);

endmodule

// File: tb/qhost_regs_test.sv
module qhost_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [3:0]  rsp_ready = 4'h0;
  logic [3:0]  req_full = 4'hF;
  logic        err_misalign = 1'b0, err_unsup = 1'b0, err_parity = 1'b0;
  logic        nq_event = 1'b0, idle = 1'b0;
  logic        irq, soft_rst, enh_mode, par_chk, par_test;
  logic [2:0]  burst_sel, burst64, xram_bank;
  logic [1:0]  eeprom_bank;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qhost_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .rsp_ready(rsp_ready), .req_full(req_full),
    .err_misalign(err_misalign), .err_unsup(err_unsup), .err_parity(err_parity),
    .nq_event(nq_event), .idle(idle), .irq(irq), .soft_rst(soft_rst),
    .burst_sel(burst_sel), .enh_mode(enh_mode), .par_chk(par_chk), .par_test(par_test),
    .burst64(burst64), .eeprom_bank(eeprom_bank), .xram_bank(xram_bank));

  // {enable word, rsp_ready, req_full, expected irq}
  localparam logic [40:0] VEC [8] = '{
    {32'h000F0F00, 4'h0, 4'hF, 1'b0},
    {32'h000F0F00, 4'h0, 4'hE, 1'b1},
    {32'h00010000, 4'h2, 4'h0, 1'b0},
    {32'h00020000, 4'h2, 4'h0, 1'b1},
    {32'h00000800, 4'hF, 4'h7, 1'b1},
    {32'h00000800, 4'hF, 4'hF, 1'b0},
    {32'h00000000, 4'hF, 4'h0, 1'b0},
    {32'h00080000, 4'h8, 4'hF, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel; #1;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 cfg", v, 0);
    rd(2'd1, v); chk("R1 err", v, 0);
    rd(2'd3, v); chk("R1 mask", v, 0);
    chk("R1 irq/srst", {irq, soft_rst}, 0);

    // R4 and R9 table
    foreach (VEC[i]) begin
      wr(2'd3, VEC[i][40:9]);
      rsp_ready = VEC[i][8:5];
      req_full  = VEC[i][4:1];
      @(negedge clk);
      chk($sformatf("R4 vec%0d irq", i), irq, VEC[i][0]);
      rd(2'd2, v); chk($sformatf("R9 vec%0d bit3", i), v[3], VEC[i][0]);
    end

    // R3 live status
    rsp_ready = 4'h5; req_full = 4'hA; idle = 1'b1;
    wr(2'd3, 32'h0);
    @(negedge clk); rd(2'd2, v); chk("R3 cmd", v, 32'h0005_0A02);
    idle = 1'b0;

    // R2 config masking and fields
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); rd(2'd0, v); chk("R2 cfg rb", v, 32'h0703_073F);
    chk("R2 fields", {21'b0, xram_bank, eeprom_bank, burst64, par_test, par_chk, enh_mode, burst_sel},
        {21'b0, 3'd7, 2'd3, 3'd7, 1'b1, 1'b1, 1'b1, 3'd7});
    wr(2'd0, 32'h0001_0215);
    @(negedge clk);
    chk("R2 fields2", {21'b0, xram_bank, eeprom_bank, burst64, par_test, par_chk, enh_mode, burst_sel},
        {21'b0, 3'd0, 2'd1, 3'd2, 1'b0, 1'b1, 1'b0, 3'd5});

    // R11 mask writable bits
    wr(2'd3, 32'hFFFF_FFFF);
    @(negedge clk); rd(2'd3, v); chk("R11 mask rb", v, 32'h000F_0F84);
    wr(2'd3, 32'h0);

    // R12 cmd write of other bits has no effect
    rsp_ready = 4'h0; req_full = 4'hF;
    wr(2'd2, 32'hFFFF_FFFA);
    @(negedge clk); rd(2'd2, v); chk("R12 cmd", v, 32'h0000_0F00);
    rd(2'd0, v); chk("R12 cfg kept", v, 32'h0001_0215);

    // R5 sticky errors
    @(negedge clk); err_unsup = 1'b1;
    @(negedge clk); err_unsup = 1'b0;
    @(negedge clk); rd(2'd1, v); chk("R5 unsup", v, 32'h2);
    err_misalign = 1'b1;
    @(negedge clk); err_misalign = 1'b0;
    @(negedge clk); rd(2'd1, v); chk("R5 misalign", v, 32'h6);
    // R7 summary bit and masked irq
    rd(2'd2, v); chk("R7 bit7", v[7], 1'b1);
    chk("R7 irq off", irq, 1'b0);
    wr(2'd3, 32'h80);
    @(negedge clk); chk("R7 irq on", irq, 1'b1);
    // R6 W1C
    wr(2'd1, 32'h4);
    @(negedge clk); rd(2'd1, v); chk("R6 w1c", v, 32'h2);
    wr(2'd1, 32'h0);
    @(negedge clk); rd(2'd1, v); chk("R6 w0 keeps", v, 32'h2);
    // R6 set wins over clear
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h3; err_parity = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0; err_parity = 1'b0;
    @(negedge clk); rd(2'd1, v); chk("R6 set wins", v, 32'h1);
    wr(2'd1, 32'h7);
    @(negedge clk); rd(2'd2, v); chk("R7 bit7 clr", v[7], 1'b0);
    chk("R7 irq clr", irq, 1'b0);

    // R8 non-queued
    wr(2'd3, 32'h0);
    @(negedge clk); nq_event = 1'b1;
    @(negedge clk); nq_event = 1'b0;
    @(negedge clk); rd(2'd2, v); chk("R8 set", v[2], 1'b1);
    chk("R8 irq masked", irq, 1'b0);
    wr(2'd3, 32'h4);
    @(negedge clk); chk("R8 irq", irq, 1'b1);
    wr(2'd2, 32'h4);
    @(negedge clk); rd(2'd2, v); chk("R8 clr", v[2], 1'b0);
    chk("R8 irq clr", irq, 1'b0);

    // R10 soft reset
    @(negedge clk); err_parity = 1'b1;
    @(negedge clk); err_parity = 1'b0;
    wr(2'd0, 32'h3F);
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk("R10 pulse", soft_rst, 1'b1);
    rd(2'd2, v); chk("R10 bit0", v[0], 1'b1);
    rd(2'd0, v); chk("R10 cfg", v, 0);
    rd(2'd3, v); chk("R10 mask", v, 0);
    rd(2'd1, v); chk("R10 err kept", v, 32'h1);
    @(negedge clk);
    chk("R10 pulse end", soft_rst, 1'b0);
    rd(2'd2, v); chk("R10 bit0 clr", v[0], 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule